// File: doc/BRIEF.md
# Streaming 3x3 Weighted-Sum Window Filter

This block applies one fixed-shape 3x3 weighted sum to an image that is fed to it one window column at a time. Every window position uses the same nine signed weights. The block holds the two most recent columns in its own registers. At the first position of a scan line, the caller supplies three columns. After that, each single new column moves the window one step to the right and yields one filtered pixel. An image of x by y pixels therefore gives (x-2) by (y-2) results. Each result belongs to the upper-left corner of its window, so the caller may write it over a source pixel that no later window still reads.

The weighted sum is held in a 20-bit signed accumulator. A programmable right shift is applied to it, and the result is clamped to the 8-bit range. Memory, address generation and bank steering are handled outside the block. The reset input is asynchronous and active low, and it is expected to be released in step with the clock.

Top module: `winsum3x3`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid_o` is 0 and `res_px_o` is 0 until the first result is produced.
- R2: A result is formed from the window after the newest column has been shifted in. Weight slot k sits at `coef_i[8k+7:8k]`, with k = 3*col + row. Column 0 is the oldest of the three columns and column 2 is the newest. Row r of a column arrives on `col_px_i[8r+7:8r]`. Pixels are unsigned and weights are two's-complement.
- R3: A column accepted with `line_start_i`=1 becomes the first column of a new line. That column and the next accepted column give no result (`res_valid_o`=0). The third accepted column of the line gives a result.
- R4: Once a line holds three columns, every further accepted column gives a result. That result uses the previous two columns together with the new one.
- R5: In a cycle with `col_valid_i`=0, the window is left unchanged, `res_valid_o` is 0 on the next cycle, and `res_px_o` keeps its value.
- R6: If the sum is negative after the shift, the output is 0.
- R7: If the sum is above 255 after the shift, the output is 255.
- R8: The sum is shifted right arithmetically by `shift_i` (0 to 15) before it is clamped.
- R9: `res_valid_o` and `res_px_o` change exactly one clock edge after the column that produces the result is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_i | input | 72 | Nine signed 8-bit weights, slot k = 3*col + row |
| shift_i | input | 4 | Arithmetic right shift applied to the sum |
| col_valid_i | input | 1 | A new column is present this cycle |
| line_start_i | input | 1 | The present column starts a scan line |
| col_px_i | input | 24 | Three unsigned 8-bit pixels of the column, row 0 in the low byte |
| res_valid_o | output | 1 | A result pixel is present |
| res_px_o | output | 8 | Filtered pixel, clamped to 0..255 |

## Verification
The hardest state to reach from the ports is a line restart that arrives while the window is already full. Mixed with it are idle gaps between columns, which must neither shift the window nor disturb the fill count. The random phase marks a new line at random points, and it sometimes does so only one or two columns after the previous restart. It also drops `col_valid_i` at random. A bench model of the column history and the fill count predicts every cycle. Directed cases drive the sum past both ends of the clamp and across several shift amounts.

// File: rtl/winsum_pkg.sv
package winsum_pkg;
  localparam int unsigned WIN    = 3;
  localparam int unsigned PIX_W  = 8;
  localparam int unsigned COEF_W = 8;
  localparam int unsigned ACC_W  = 20;
  localparam int unsigned SH_W   = 4;
  localparam int unsigned TAPS   = WIN * WIN;
  localparam int unsigned CNT_W  = $clog2(WIN + 1);
endpackage

// File: rtl/winsum_colregs.sv
module winsum_colregs
  import winsum_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept_i,
  input  logic                      restart_i,
  input  logic [WIN*PIX_W-1:0]      col_i,
  output logic [TAPS*PIX_W-1:0]     win_nxt_o,
  output logic                      full_nxt_o
);
  localparam int unsigned COL_BITS = WIN * PIX_W;
  localparam int unsigned WIN_BITS = TAPS * PIX_W;

  logic [WIN_BITS-1:0] win_q, win_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;

  always_comb begin
    win_d = win_q;
    cnt_d = cnt_q;
    if (accept_i) begin
      win_d = {col_i, win_q[WIN_BITS-1:COL_BITS]};
      if (restart_i)
        cnt_d = CNT_W'(1);
      else if (cnt_q != CNT_W'(WIN))
        cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (accept_i) begin
      win_q <= win_d;
      cnt_q <= cnt_d;
    end
  end

  assign win_nxt_o  = win_d;
  assign full_nxt_o = (cnt_d == CNT_W'(WIN));
endmodule

// File: rtl/winsum_mac.sv
module winsum_mac
  import winsum_pkg::*;
(
  input  logic [TAPS*PIX_W-1:0]     win_i,
  input  logic [TAPS*COEF_W-1:0]    coef_i,
  output logic signed [ACC_W-1:0]   acc_o
);
  localparam int unsigned PROD_W = PIX_W + 1 + COEF_W;

  logic signed [PROD_W-1:0] prod [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign prod[g] = $signed({1'b0, win_i[g*PIX_W +: PIX_W]}) *
                     $signed(coef_i[g*COEF_W +: COEF_W]);
  end

  always_comb begin
    acc_o = '0;
    for (int k = 0; k < TAPS; k++)
      acc_o = acc_o + ACC_W'(prod[k]);
  end
endmodule

// File: rtl/winsum_clamp.sv
module winsum_clamp
  import winsum_pkg::*;
(
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [SH_W-1:0]         shift_i,
  output logic [PIX_W-1:0]        pix_o
);
  logic signed [ACC_W-1:0] shifted;

  always_comb begin
    shifted = acc_i >>> shift_i;
    if (shifted[ACC_W-1])
      pix_o = '0;
    else if (|shifted[ACC_W-2:PIX_W])
      pix_o = '1;
    else
      pix_o = shifted[PIX_W-1:0];
  end
endmodule

// File: rtl/winsum3x3.sv
module winsum3x3
  import winsum_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TAPS*COEF_W-1:0]  coef_i,
  input  logic [SH_W-1:0]         shift_i,
  input  logic                    col_valid_i,
  input  logic                    line_start_i,
  input  logic [WIN*PIX_W-1:0]    col_px_i,
  output logic                    res_valid_o,
  output logic [PIX_W-1:0]        res_px_o
);
  logic [TAPS*PIX_W-1:0]   win_nxt;
  logic                    full_nxt;
  logic signed [ACC_W-1:0] acc;
  logic [PIX_W-1:0]        pix;
  logic                    valid_d, valid_q;
  logic [PIX_W-1:0]        px_d, px_q;
  logic                    px_en;

  winsum_colregs u_cols (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (col_valid_i),
    .restart_i  (line_start_i),
    .col_i      (col_px_i),
    .win_nxt_o  (win_nxt),
    .full_nxt_o (full_nxt)
  );

  winsum_mac u_mac (
    .win_i  (win_nxt),
    .coef_i (coef_i),
    .acc_o  (acc)
  );

  winsum_clamp u_clamp (
    .acc_i   (acc),
    .shift_i (shift_i),
    .pix_o   (pix)
  );

  always_comb begin
    valid_d = col_valid_i && full_nxt;
    px_en   = valid_d;
    px_d    = pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     px_q <= '0;
    else if (px_en) px_q <= px_d;
  end

  assign res_valid_o = valid_q;
  assign res_px_o    = px_q;
endmodule

// File: rtl/winsum3x3_chk.sv
module winsum3x3_chk
  import winsum_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             col_valid_i,
  input logic             line_start_i,
  input logic             res_valid_o,
  input logic [PIX_W-1:0] res_px_o
);
  // R5
  idle_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid_i |=> !res_valid_o);

  // R5
  idle_holds_px_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid_i |=> $stable(res_px_o));

  // R3
  restart_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid_i && line_start_i) |=> !res_valid_o);

  // R4
  full_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && col_valid_i && !line_start_i) |=> res_valid_o);

  // R9
  result_follows_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid_o) |-> $past(col_valid_i));
endmodule

bind winsum3x3 winsum3x3_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .col_valid_i  (col_valid_i),
  .line_start_i (line_start_i),
  .res_valid_o  (res_valid_o),
  .res_px_o     (res_px_o)
);

// File: tb/sim_winsum3x3.sv
module sim_winsum3x3;
  localparam time HALF = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [71:0] coef;
  logic [3:0]  shift;
  logic        cv, ls;
  logic [23:0] col;
  logic        rv;
  logic [7:0]  rp;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int bw [9];
  int mcnt = 0;
  bit mval = 0;
  int mpx  = 0;

  always #HALF clk = ~clk;

  winsum3x3 u0 (
    .clk(clk), .rst_n(rst_n), .coef_i(coef), .shift_i(shift),
    .col_valid_i(cv), .line_start_i(ls), .col_px_i(col),
    .res_valid_o(rv), .res_px_o(rp)
  );

  function automatic int model_px();
    int s = 0;
    for (int k = 0; k < 9; k++)
      s += bw[k] * int'($signed(coef[k*8 +: 8]));
    s = s >>> shift;
    if (s < 0) return 0;
    if (s > 255) return 255;
    return s;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit l, input [23:0] c, input string tag);
    cv = v; ls = l; col = c;
    @(posedge clk); #1;
    if (v) begin
      if (l) mcnt = 1; else if (mcnt < 3) mcnt++;
      for (int k = 0; k < 6; k++) bw[k] = bw[k+3];
      for (int r = 0; r < 3; r++) bw[6+r] = int'(c[r*8 +: 8]);
      mval = (mcnt == 3);
      if (mval) mpx = model_px();
    end else mval = 0;
    chk({tag, " valid"}, int'(rv), int'(mval));
    chk({tag, " pixel"}, int'(rp), mpx);
    cv = 0; ls = 0;
  endtask

  function automatic [71:0] fill_coef(input int w);
    logic [71:0] c;
    for (int k = 0; k < 9; k++) c[k*8 +: 8] = 8'(w);
    return c;
  endfunction

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    for (int k = 0; k < 9; k++) bw[k] = 0;
    rst_n = 0; cv = 0; ls = 0; col = '0; coef = fill_coef(1); shift = 0;
    #3;
    chk("R1 in reset valid", int'(rv), 0);
    chk("R1 in reset pixel", int'(rp), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(0, 0, 24'h0, "R1 after reset");

    // R2 R3: unit weights, 1..9
    step(1, 1, {8'd3, 8'd2, 8'd1}, "R3 first col");
    step(1, 0, {8'd6, 8'd5, 8'd4}, "R3 second col");
    step(1, 0, {8'd9, 8'd8, 8'd7}, "R2 R9 third col");
    chk("R2 sum 45", int'(rp), 45);
    // R4 overlap
    step(1, 0, {8'd10, 8'd10, 8'd10}, "R4 next col");
    chk("R4 sum 69", int'(rp), 69);
    // R2 position weighting: only newest-col row 2 weighted
    coef = '0; coef[8*8 +: 8] = 8'd2;
    step(1, 0, {8'd50, 8'd0, 8'd0}, "R2 slot 8");
    chk("R2 slot weight", int'(rp), 100);
    // R5 idle
    step(0, 0, 24'hFFFFFF, "R5 idle 1");
    step(0, 0, 24'hFFFFFF, "R5 idle 2");
    step(1, 0, {8'd20, 8'd0, 8'd0}, "R5 window kept");
    // R6 negative clamp
    coef = fill_coef(-1);
    step(1, 0, {8'd200, 8'd200, 8'd200}, "R6 negative");
    chk("R6 zero", int'(rp), 0);
    // R7 high clamp, R8 shift
    coef = fill_coef(127);
    step(1, 0, 24'hFFFFFF, "R7 fill");
    step(1, 0, 24'hFFFFFF, "R7 fill");
    step(1, 0, 24'hFFFFFF, "R7 saturate");
    chk("R7 max", int'(rp), 255);
    shift = 4'd12;
    step(1, 0, 24'hFFFFFF, "R8 shift 12");
    chk("R8 291465>>12", int'(rp), 71);
    coef = fill_coef(-128); shift = 4'd15;
    step(1, 0, 24'hFFFFFF, "R8 R6 negative shift");
    // R3 restart while full
    coef = fill_coef(1); shift = 0;
    step(1, 1, {8'd1, 8'd1, 8'd1}, "R3 restart col1");
    step(1, 0, {8'd1, 8'd1, 8'd1}, "R3 restart col2");
    step(1, 0, {8'd1, 8'd1, 8'd1}, "R3 restart col3");
    chk("R3 restart sum", int'(rp), 9);

    // random lines
    for (int ln = 0; ln < 40; ln++) begin
      for (int k = 0; k < 9; k++) coef[k*8 +: 8] = 8'($urandom);
      shift = 4'($urandom_range(0, 9));
      for (int s = 0; s < 22; s++) begin
        bit v = ($urandom_range(0, 3) != 0);
        bit l = (s == 0) || ($urandom_range(0, 15) == 0);
        step(v, l && v, 24'($urandom), "R2 R4 random");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule